// File: doc/BRIEF.md
# Segment-Based Address Translator with Access Protection

This unit maps a logical address, given as a segment number and an offset within that segment, onto a physical address. An eight-entry register table holds, for each segment, a physical start address, a segment length and three permission bits. These bits allow reads, writes and instruction fetches. A user-mode request is checked in two ways. The offset must lie inside the segment, and the access kind must be allowed by the entry. If both checks pass, the start address is added to the offset. If either check fails, the unit raises a protection fault and issues no address. Requests made in kernel mode skip both checks, and the logical address passes through unchanged.

The table is loaded through a configuration port. A load is accepted only while the privilege input is high. A load attempted without privilege leaves the table as it was and raises a privilege-error pulse. The result of each request is registered. A small response state machine, with states RSP_IDLE, RSP_PASS and RSP_FAULT, holds that result. It moves to RSP_PASS on a request that passes its checks and to RSP_FAULT on a request that fails them. It returns to RSP_IDLE on any cycle without a request.

Top module: `seg_xlate`

## Requirements
- R1: After reset every response output and the privilege-error output are low, and every table entry has length zero, so any user-mode request to a segment that has not been loaded faults.
- R2: A user-mode request whose offset is below the entry's length, and whose kind is allowed, produces rsp_valid_o high, fault_o low and rsp_pa_o equal to start plus offset. These appear in the cycle after the request and last exactly one cycle.
- R3: A user-mode request whose offset is equal to or greater than the entry's length produces rsp_valid_o and fault_o high and rsp_pa_o zero in the following cycle.
- R4: Access kind codes are 0 read, 1 write, 2 fetch and 3 reserved. Permission bit 0 allows read, bit 1 allows write and bit 2 allows fetch. A user-mode request whose kind is not allowed by its entry faults, and so does any request with the reserved code.
- R5: A kernel-mode request (priv_i high) never faults, whatever the entry holds. It yields rsp_pa_o equal to the segment number concatenated above the offset, zero-extended.
- R6: A configuration load made with priv_i high replaces the selected entry's start, length and permissions, and a request in the next cycle already sees the new values.
- R7: A configuration load made with priv_i low leaves the table unchanged and raises priv_err_o for exactly the following cycle. priv_err_o is low in every other cycle.
- R8: A cycle without a request leaves rsp_valid_o, fault_o and rsp_pa_o all low in the following cycle.
- R9: The sum of start and offset wraps modulo 2^PA_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| priv_i | input | 1 | High for kernel mode |
| cfg_we_i | input | 1 | Configuration load strobe |
| cfg_idx_i | input | SEG_W (3) | Entry to load |
| cfg_base_i | input | PA_W (16) | Physical start address |
| cfg_limit_i | input | OFS_W+1 (13) | Segment length |
| cfg_perm_i | input | 3 | Permissions: bit0 read, bit1 write, bit2 fetch |
| req_valid_i | input | 1 | Request strobe |
| req_kind_i | input | 2 | Access kind code |
| req_seg_i | input | SEG_W (3) | Segment number |
| req_ofs_i | input | OFS_W (12) | Offset within segment |
| rsp_valid_o | output | 1 | Registered response valid |
| rsp_pa_o | output | PA_W (16) | Registered physical address, zero on fault |
| fault_o | output | 1 | Registered protection fault |
| priv_err_o | output | 1 | Unprivileged load attempt, one-cycle pulse |

## Verification
Requests are sent to four segments with different permissions. The offsets tested are zero, the last legal offset and the first illegal offset, which separates an off-by-one bound from a correct one. Each access kind is sent both to entries that allow it and to entries that forbid it. This exposes a swapped or ignored permission bit. A segment whose start is near the top of the space catches a sum that is saturated or widened instead of wrapped. Kernel requests aimed at a length-zero entry and beyond a bound show that the bypass really skips both checks. Loads made with and without privilege, each followed straight away by a request, show when a load takes effect and that a refused load changes nothing.

// File: rtl/seg_pkg.sv
package seg_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_kind_e;

    localparam int PERM_W   = 3;
    localparam int PERM_RD  = 0;
    localparam int PERM_WR  = 1;
    localparam int PERM_EX  = 2;

    typedef enum logic [1:0] {
        RSP_IDLE  = 2'd0,
        RSP_PASS  = 2'd1,
        RSP_FAULT = 2'd2
    } rsp_state_e;

endpackage

// File: rtl/seg_table.sv
module seg_table #(
    parameter int SEG_W = 3,
    parameter int PA_W  = 16,
    parameter int LIM_W = 13
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [SEG_W-1:0]         wr_idx,
    input  logic [PA_W-1:0]          wr_base,
    input  logic [LIM_W-1:0]         wr_limit,
    input  logic [seg_pkg::PERM_W-1:0] wr_perm,
    input  logic [SEG_W-1:0]         rd_idx,
    output logic [PA_W-1:0]          rd_base,
    output logic [LIM_W-1:0]         rd_limit,
    output logic [seg_pkg::PERM_W-1:0] rd_perm
);
    localparam int N_SEG = 1 << SEG_W;

    logic [PA_W-1:0]            base_q  [N_SEG];
    logic [LIM_W-1:0]           limit_q [N_SEG];
    logic [seg_pkg::PERM_W-1:0] perm_q  [N_SEG];

    for (genvar g = 0; g < N_SEG; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                base_q[g]  <= '0;
                limit_q[g] <= '0;
                perm_q[g]  <= '0;
            end else if (wr_en && (wr_idx == SEG_W'(g))) begin
                base_q[g]  <= wr_base;
                limit_q[g] <= wr_limit;
                perm_q[g]  <= wr_perm;
            end
        end
    end

    assign rd_base  = base_q[rd_idx];
    assign rd_limit = limit_q[rd_idx];
    assign rd_perm  = perm_q[rd_idx];

endmodule

// File: rtl/seg_check.sv
module seg_check
    import seg_pkg::*;
#(
    parameter int SEG_W = 3,
    parameter int OFS_W = 12,
    parameter int PA_W  = 16,
    parameter int LIM_W = 13
) (
    input  logic               priv,
    input  acc_kind_e          kind,
    input  logic [SEG_W-1:0]   seg,
    input  logic [OFS_W-1:0]   ofs,
    input  logic [PA_W-1:0]    base,
    input  logic [LIM_W-1:0]   limit,
    input  logic [PERM_W-1:0]  perm,
    output logic               fault,
    output logic [PA_W-1:0]    pa
);
    localparam int LA_W = SEG_W + OFS_W;

    logic in_bound;
    logic kind_ok;

    always_comb begin
        in_bound = (LIM_W'(ofs) < limit);
        unique case (kind)
            ACC_READ:  kind_ok = perm[PERM_RD];
            ACC_WRITE: kind_ok = perm[PERM_WR];
            ACC_FETCH: kind_ok = perm[PERM_EX];
            default:   kind_ok = 1'b0;
        endcase
        if (priv) begin
            fault = 1'b0;
            pa    = PA_W'({seg, ofs});
        end else begin
            fault = !(in_bound && kind_ok);
            pa    = base + PA_W'(ofs);
        end
    end

endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
    import seg_pkg::*;
#(
    parameter int SEG_W = 3,
    parameter int OFS_W = 12,
    parameter int PA_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               priv_i,
    input  logic               cfg_we_i,
    input  logic [SEG_W-1:0]   cfg_idx_i,
    input  logic [PA_W-1:0]    cfg_base_i,
    input  logic [OFS_W:0]     cfg_limit_i,
    input  logic [2:0]         cfg_perm_i,
    input  logic               req_valid_i,
    input  logic [1:0]         req_kind_i,
    input  logic [SEG_W-1:0]   req_seg_i,
    input  logic [OFS_W-1:0]   req_ofs_i,
    output logic               rsp_valid_o,
    output logic [PA_W-1:0]    rsp_pa_o,
    output logic               fault_o,
    output logic               priv_err_o
);
    localparam int LIM_W = OFS_W + 1;

    logic [PA_W-1:0]   ent_base;
    logic [LIM_W-1:0]  ent_limit;
    logic [PERM_W-1:0] ent_perm;
    logic              chk_fault;
    logic [PA_W-1:0]   chk_pa;
    logic              cfg_ok;

    rsp_state_e        state_q, state_d;
    logic [PA_W-1:0]   pa_q;
    logic              perr_q;

    assign cfg_ok = cfg_we_i && priv_i;

    seg_table #(.SEG_W(SEG_W), .PA_W(PA_W), .LIM_W(LIM_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_ok),
        .wr_idx   (cfg_idx_i),
        .wr_base  (cfg_base_i),
        .wr_limit (cfg_limit_i),
        .wr_perm  (cfg_perm_i),
        .rd_idx   (req_seg_i),
        .rd_base  (ent_base),
        .rd_limit (ent_limit),
        .rd_perm  (ent_perm)
    );

    seg_check #(.SEG_W(SEG_W), .OFS_W(OFS_W), .PA_W(PA_W), .LIM_W(LIM_W)) u_check (
        .priv  (priv_i),
        .kind  (acc_kind_e'(req_kind_i)),
        .seg   (req_seg_i),
        .ofs   (req_ofs_i),
        .base  (ent_base),
        .limit (ent_limit),
        .perm  (ent_perm),
        .fault (chk_fault),
        .pa    (chk_pa)
    );

    // next-state selection
    always_comb begin
        unique case (state_q)
            RSP_IDLE, RSP_PASS, RSP_FAULT: begin
                if (!req_valid_i)   state_d = RSP_IDLE;
                else if (chk_fault) state_d = RSP_FAULT;
                else                state_d = RSP_PASS;
            end
            default: state_d = RSP_IDLE;
        endcase
    end

    // state and data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RSP_IDLE;
            pa_q    <= '0;
            perr_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            pa_q    <= (state_d == RSP_PASS) ? chk_pa : '0;
            perr_q  <= cfg_we_i && !priv_i;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            RSP_PASS: begin
                rsp_valid_o = 1'b1;
                fault_o     = 1'b0;
            end
            RSP_FAULT: begin
                rsp_valid_o = 1'b1;
                fault_o     = 1'b1;
            end
            default: begin
                rsp_valid_o = 1'b0;
                fault_o     = 1'b0;
            end
        endcase
        rsp_pa_o   = pa_q;
        priv_err_o = perr_q;
    end

endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
    parameter int SEG_W = 3,
    parameter int OFS_W = 12,
    parameter int PA_W  = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             priv_i,
    input logic             cfg_we_i,
    input logic             req_valid_i,
    input logic [SEG_W-1:0] req_seg_i,
    input logic [OFS_W-1:0] req_ofs_i,
    input logic             rsp_valid_o,
    input logic [PA_W-1:0]  rsp_pa_o,
    input logic             fault_o,
    input logic             priv_err_o
);
    logic [PA_W-1:0] pass_addr;
    assign pass_addr = PA_W'({req_seg_i, req_ofs_i});

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_i |=> rsp_valid_o); // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid_i |=> (!rsp_valid_o && !fault_o && rsp_pa_o == '0)); // R8
    AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (rsp_valid_o && rsp_pa_o == '0)); // R3
    AST_KERNEL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && priv_i) |=> (!fault_o && rsp_pa_o == $past(pass_addr))); // R5
    AST_PRIV_ERR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we_i && !priv_i) |=> priv_err_o); // R7
    AST_PRIV_ERR_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we_i && !priv_i) |=> !priv_err_o); // R7

endmodule

bind seg_xlate seg_xlate_chk #(.SEG_W(SEG_W), .OFS_W(OFS_W), .PA_W(PA_W)) u_seg_xlate_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .priv_i      (priv_i),
    .cfg_we_i    (cfg_we_i),
    .req_valid_i (req_valid_i),
    .req_seg_i   (req_seg_i),
    .req_ofs_i   (req_ofs_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_pa_o    (rsp_pa_o),
    .fault_o     (fault_o),
    .priv_err_o  (priv_err_o)
);

// File: tb/test_seg_xlate.sv
module test_seg_xlate;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        priv_i = 1'b0;
    logic        cfg_we_i = 1'b0;
    logic [2:0]  cfg_idx_i = '0;
    logic [15:0] cfg_base_i = '0;
    logic [12:0] cfg_limit_i = '0;
    logic [2:0]  cfg_perm_i = '0;
    logic        req_valid_i = 1'b0;
    logic [1:0]  req_kind_i = '0;
    logic [2:0]  req_seg_i = '0;
    logic [11:0] req_ofs_i = '0;
    logic        rsp_valid_o;
    logic [15:0] rsp_pa_o;
    logic        fault_o;
    logic        priv_err_o;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    seg_xlate i_seg_xlate (.*);

    typedef struct packed {
        logic        priv;
        logic [1:0]  kind;
        logic [2:0]  seg;
        logic [11:0] ofs;
        logic        efault;
        logic [15:0] epa;
    } vec_t;

    // kind: 0 read, 1 write, 2 fetch, 3 reserved
    localparam vec_t VECS [12] = '{
        '{1'b0, 2'd0, 3'd0, 12'h0FF, 1'b0, 16'h10FF}, // R2 last legal offset
        '{1'b0, 2'd0, 3'd0, 12'h100, 1'b1, 16'h0000}, // R3 first illegal offset
        '{1'b0, 2'd1, 3'd0, 12'h010, 1'b0, 16'h1010}, // R2 write allowed
        '{1'b0, 2'd2, 3'd0, 12'h010, 1'b1, 16'h0000}, // R4 fetch denied
        '{1'b0, 2'd2, 3'd1, 12'hFFF, 1'b0, 16'h8FFF}, // R2 full-length segment
        '{1'b0, 2'd0, 3'd1, 12'h000, 1'b1, 16'h0000}, // R4 read denied
        '{1'b0, 2'd0, 3'd2, 12'h150, 1'b0, 16'h0050}, // R9 wrap
        '{1'b0, 2'd1, 3'd2, 12'h000, 1'b1, 16'h0000}, // R4 write denied
        '{1'b0, 2'd0, 3'd3, 12'h000, 1'b1, 16'h0000}, // R1 unloaded entry
        '{1'b1, 2'd1, 3'd3, 12'h123, 1'b0, 16'h3123}, // R5 kernel, zero length
        '{1'b1, 2'd2, 3'd0, 12'h800, 1'b0, 16'h0800}, // R5 kernel, beyond bound
        '{1'b0, 2'd3, 3'd0, 12'h000, 1'b1, 16'h0000}  // R4 reserved kind
    };

    task automatic check(input logic ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load(input logic p, input logic [2:0] idx, input logic [15:0] b,
                        input logic [12:0] l, input logic [2:0] pm);
        @(negedge clk);
        priv_i = p; cfg_we_i = 1'b1; cfg_idx_i = idx;
        cfg_base_i = b; cfg_limit_i = l; cfg_perm_i = pm;
        @(negedge clk);
        cfg_we_i = 1'b0; priv_i = 1'b0;
    endtask

    task automatic request(input logic p, input logic [1:0] k, input logic [2:0] s,
                           input logic [11:0] o);
        @(negedge clk);
        priv_i = p; req_valid_i = 1'b1; req_kind_i = k; req_seg_i = s; req_ofs_i = o;
        @(negedge clk);
        req_valid_i = 1'b0; priv_i = 1'b0;
    endtask

    task automatic check_rsp(input string req, input logic ef, input logic [15:0] ep);
        check(rsp_valid_o == 1'b1, req, 32'(rsp_valid_o), 32'd1);
        check(fault_o == ef, req, 32'(fault_o), 32'(ef));
        check(rsp_pa_o == ep, req, 32'(rsp_pa_o), 32'(ep));
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(!rsp_valid_o && !fault_o && !priv_err_o && rsp_pa_o == '0, "R1 in reset",
              {13'd0, rsp_valid_o, fault_o, priv_err_o, rsp_pa_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!rsp_valid_o && !fault_o && !priv_err_o, "R1 after reset",
              {29'd0, rsp_valid_o, fault_o, priv_err_o}, 32'd0);
        request(1'b0, 2'd0, 3'd5, 12'h000);
        check_rsp("R1 reset length zero", 1'b1, 16'h0000);

        // perm: bit0 read, bit1 write, bit2 fetch
        load(1'b1, 3'd0, 16'h1000, 13'h0100, 3'b011);
        check(priv_err_o == 1'b0, "R7 privileged load no error", 32'(priv_err_o), 32'd0);
        load(1'b1, 3'd1, 16'h8000, 13'h1000, 3'b100);
        load(1'b1, 3'd2, 16'hFF00, 13'h0200, 3'b001);

        foreach (VECS[i]) begin
            request(VECS[i].priv, VECS[i].kind, VECS[i].seg, VECS[i].ofs);
            check_rsp($sformatf("R2/R3/R4/R5/R9 vector %0d", i), VECS[i].efault, VECS[i].epa);
        end

        // R8: idle cycle after a response
        @(negedge clk);
        check(!rsp_valid_o && !fault_o && rsp_pa_o == '0, "R8 idle",
              {15'd0, rsp_valid_o, fault_o, rsp_pa_o}, 32'd0);

        // R7: unprivileged load refused, table unchanged
        load(1'b0, 3'd0, 16'h0000, 13'h0000, 3'b000);
        check(priv_err_o == 1'b1, "R7 error pulse", 32'(priv_err_o), 32'd1);
        @(negedge clk);
        check(priv_err_o == 1'b0, "R7 pulse ends", 32'(priv_err_o), 32'd0);
        request(1'b0, 2'd0, 3'd0, 12'h0FF);
        check_rsp("R7 entry unchanged", 1'b0, 16'h10FF);

        // R6: load then immediate request
        @(negedge clk);
        priv_i = 1'b1; cfg_we_i = 1'b1; cfg_idx_i = 3'd3;
        cfg_base_i = 16'h2000; cfg_limit_i = 13'h0010; cfg_perm_i = 3'b010;
        @(negedge clk);
        cfg_we_i = 1'b0; priv_i = 1'b0;
        req_valid_i = 1'b1; req_kind_i = 2'd1; req_seg_i = 3'd3; req_ofs_i = 12'h00F;
        @(negedge clk);
        req_valid_i = 1'b0;
        check_rsp("R6 new entry used next cycle", 1'b0, 16'h200F);
        request(1'b0, 2'd1, 3'd3, 12'h010);
        check_rsp("R6 new bound", 1'b1, 16'h0000);

        // R2: response lasts one cycle
        request(1'b0, 2'd1, 3'd0, 12'h020);
        check_rsp("R2 write", 1'b0, 16'h1020);
        @(negedge clk);
        check(rsp_valid_o == 1'b0, "R2 one-cycle response", 32'(rsp_valid_o), 32'd0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule